// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog

This block is a countdown watchdog that does not reset the system on its first timeout. A down-counter advances on an external tick. When it passes zero, it reloads from a programmable register and raises a sticky expiry flag. A system reset is issued only when a later expiry finds that flag still raised. Software services the watchdog in one of two ways: it rewrites the counter with a keepalive, or it clears the flag by writing a one to it. With a reload value of R, a hung system is therefore reset between R+1 and 2(R+1) ticks after its last service.

A control bit routes each expiry to a management-interrupt request instead. A one-cycle request pulse accompanies the flag, and the flag is cleared on the next clock, which stands in for the handler's service. While that bit is set, unserviced expiries never accumulate, so the watchdog stays harmless until software clears the bit and takes over. The reset output stays high for a fixed number of cycles. After that, every register returns to its reset value.

Register map (2-bit word address, DATA_W-bit data): address 0 is control, address 1 is status, address 2 is reload, and address 3 is keepalive on write and the live count on read.

Top module: `dual_expiry_wdog`

## Requirements
- R1: After rst_n, control reads 0x2000 (interrupt routing bit 13 set), status reads 0, reload and count both read RELOAD_INIT, and smi_req and sys_rst are low.
- R2: The count at address 3 decreases by one on each clock with tick high and holds when tick is low. A tick with the count at zero is an expiry, which reloads the count from address 2, so expiries are R+1 ticks apart.
- R3: An expiry sets the flag at status bit 3 (address 1 reads 0x0008) in the clock after that expiry. The flag then stays set until it is cleared.
- R4: A write to address 1 with bit 3 set clears the flag. A write with bit 3 clear leaves it unchanged.
- R5: Any write to address 3 reloads the count from address 2 and clears the flag. It takes precedence over an expiry in the same cycle.
- R6: An expiry that finds the flag still set, and not being cleared by the interrupt path in that cycle, raises sys_rst on the next clock. An expiry that finds the flag clear does not raise it.
- R7: sys_rst stays high for exactly RST_HOLD cycles. During that time, writes are ignored and the count is frozen. On release, every register holds its R1 value.
- R8: With control bit 13 set, each expiry raises smi_req for one cycle, in the same clock as the flag. The flag is cleared on the following clock, so repeated expiries never cause a reset.
- R9: With control bit 13 clear, smi_req stays low.
- R10: Address 2 holds the low CNT_W bits of the write data, and its upper read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| tick | input | 1 | Count enable, one decrement per high cycle |
| smi_req | output | 1 | Management-interrupt request pulse |
| sys_rst | output | 1 | System reset request |

## Verification
The bench uses a 4-bit counter with RELOAD_INIT of 5 and RST_HOLD of 3. With these sizes, every legal reload value from 0 to 15 can be swept through the whole first-expiry, second-expiry and reset-release sequence, with both delays checked against R+1 and 2(R+1). The short hold allows the release to defaults to be checked after every sweep point. It also leaves room to check clearing the flag, keepalive and interrupt routing, where the pulse and flag counts over a fixed window follow from the reload period.

// File: rtl/dual_expiry_wdog.sv
module dual_expiry_wdog #(
  parameter int CNT_W       = 8,
  parameter int RELOAD_INIT = 200,
  parameter int RST_HOLD    = 16,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick,
  output logic              smi_req,
  output logic              sys_rst
);
  localparam int HOLD_W   = $clog2(RST_HOLD + 1);
  localparam int SMI_BIT  = 13;
  localparam int FLAG_BIT = 3;

  logic [CNT_W-1:0]  count, reload;
  logic [HOLD_W-1:0] hold;
  logic              flag, smi_en;

  wire holding   = hold != '0;
  wire wr_ok     = wr_en & ~holding;
  wire kick      = wr_ok && addr == 2'd3;
  wire w1c       = wr_ok && addr == 2'd1 && wdata[FLAG_BIT];
  wire expire    = tick && count == '0 && !holding && !kick;
  wire smi_clear = smi_req & smi_en;
  wire fire      = expire & flag & ~smi_clear;

  assign sys_rst = holding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= CNT_W'(RELOAD_INIT);
      reload  <= CNT_W'(RELOAD_INIT);
      flag    <= 1'b0;
      smi_en  <= 1'b1;
      smi_req <= 1'b0;
      hold    <= '0;
    end else if (hold == HOLD_W'(1)) begin
      count   <= CNT_W'(RELOAD_INIT);
      reload  <= CNT_W'(RELOAD_INIT);
      flag    <= 1'b0;
      smi_en  <= 1'b1;
      smi_req <= 1'b0;
      hold    <= '0;
    end else if (holding) begin
      hold    <= hold - 1'b1;
      smi_req <= 1'b0;
    end else begin
      smi_req <= expire & smi_en & ~fire;
      if (fire) hold <= HOLD_W'(RST_HOLD);

      if (kick || expire) count <= reload;
      else if (tick)      count <= count - 1'b1;

      if (expire)                        flag <= 1'b1;
      else if (kick || w1c || smi_clear) flag <= 1'b0;

      if (wr_ok && addr == 2'd0) smi_en <= wdata[SMI_BIT];
      if (wr_ok && addr == 2'd2) reload <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = DATA_W'(smi_en) << SMI_BIT;
      2'd1:    rdata = DATA_W'(flag) << FLAG_BIT;
      2'd2:    rdata = DATA_W'(reload);
      default: rdata = DATA_W'(count);
    endcase
  end
endmodule

module dual_expiry_wdog_chk #(
  parameter int CNT_W       = 8,
  parameter int RELOAD_INIT = 200,
  parameter int RST_HOLD    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             smi_req,
  input logic             sys_rst,
  input logic             flag,
  input logic             smi_en,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload
);
  localparam int RUN_W = $clog2(RST_HOLD + 2);
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       run <= '0;
    else if (sys_rst) run <= run + 1'b1;
    else              run <= '0;

  p_rst_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(flag));

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_en && !(smi_req && smi_en) && !sys_rst) |=> flag);

  p_smi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && smi_en && !expire && !sys_rst) |=> !flag);

  p_smi_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> $past(smi_en));

  p_hold_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> run < RUN_W'(RST_HOLD));

  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && $past(sys_rst)) |-> $stable(count));

  p_release_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (smi_en && !flag && reload == CNT_W'(RELOAD_INIT)));
endmodule

bind dual_expiry_wdog dual_expiry_wdog_chk #(
  .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT), .RST_HOLD(RST_HOLD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .smi_req(smi_req),
  .sys_rst(sys_rst), .flag(flag), .smi_en(smi_en), .expire(expire),
  .count(count), .reload(reload)
);

// File: tb/dual_expiry_wdog_bench.sv
`timescale 1ns/1ps
module dual_expiry_wdog_bench;
  localparam int CW = 4, RI = 5, RH = 3, DW = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic smi_req, sys_rst;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dual_expiry_wdog #(.CNT_W(CW), .RELOAD_INIT(RI), .RST_HOLD(RH), .DATA_W(DW)) u_dual_expiry_wdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .smi_req(smi_req), .sys_rst(sys_rst));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int n, m, h, s, f, q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(0, d); chk("R1 control", d, 16'h2000);
    rd(1, d); chk("R1 status", d, 0);
    rd(2, d); chk("R1 reload", d, RI);
    rd(3, d); chk("R1 count", d, RI);
    chk("R1 sys_rst", sys_rst, 0);
    chk("R1 smi_req", smi_req, 0);

    repeat (4) @(negedge clk);
    rd(3, d); chk("R2 count holds without tick", d, RI);
    @(negedge clk); tick = 1;
    @(negedge clk); @(negedge clk); tick = 0;
    rd(3, d); chk("R2 two ticks", d, RI - 2);

    wr(2, 16'hFFFF);
    rd(2, d); chk("R10 reload masked", d, 15);

    for (int r = 0; r < 16; r++) begin
      tick = 0;
      wr(0, 0);
      wr(2, DW'(r));
      tick = 1;
      wr(3, 0);
      n = 0;
      do begin
        @(negedge clk); n++; rd(1, d);
      end while (d == 0 && n < 100);
      chk("R3 first expiry delay", n, r + 1);
      chk("R6 no reset on first expiry", sys_rst, 0);
      m = n;
      do begin
        @(negedge clk); m++;
      end while (!sys_rst && m < 100);
      chk("R6 reset at second expiry", m, 2 * (r + 1));
      h = 1;
      forever begin
        wr_en = 1; addr = 2; wdata = 9;
        @(negedge clk); wr_en = 0;
        if (sys_rst) h++; else break;
      end
      chk("R7 hold length", h, RH);
      tick = 0;
      rd(2, d); chk("R7 reload default, write ignored", d, RI);
      rd(0, d); chk("R7 control default", d, 16'h2000);
      rd(1, d); chk("R7 flag cleared", d, 0);
    end

    tick = 0;
    wr(0, 0); wr(2, 3);
    tick = 1; wr(3, 0);
    n = 0;
    do begin @(negedge clk); n++; rd(1, d); end while (d == 0 && n < 100);
    tick = 0;
    wr(1, 16'hFFF7);
    rd(1, d); chk("R4 zero in bit 3 no effect", d, 8);
    wr(1, 16'h0008);
    rd(1, d); chk("R4 write one clears", d, 0);
    tick = 1;
    n = 0;
    do begin @(negedge clk); n++; rd(1, d); end while (d == 0 && n < 100);
    chk("R6 cleared flag gives no reset", sys_rst, 0);
    chk("R3 flag set again", d, 8);
    tick = 0;
    wr(3, 0);
    rd(1, d); chk("R5 keepalive clears flag", d, 0);
    rd(3, d); chk("R5 keepalive reloads", d, 3);

    wr(0, 16'h2000); wr(2, 2);
    tick = 1; wr(3, 0);
    s = 0; f = 0; q = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); rd(1, d);
      if (smi_req) s++;
      if (d != 0) f++;
      if (sys_rst) q++;
    end
    chk("R8 smi pulses", s, 10);
    chk("R8 flag high cycles", f, 10);
    chk("R8 no reset", q, 0);

    tick = 0;
    wr(0, 0);
    tick = 1; wr(3, 0);
    s = 0; q = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (smi_req) s++;
      if (sys_rst) q++;
    end
    chk("R9 no smi when routing off", s, 0);
    chk("R9 reset reached", q > 0, 1);
    tick = 0;
    repeat (RH + 2) @(negedge clk);

    finish_run();
  end
endmodule